// File: doc/BRIEF.md
# Flash Sector Rewrite Sequencer

This block changes individual bytes of a serial NOR flash in which the sector is the smallest unit that can be erased. It works on the whole sector. It copies the sector into a local buffer and keeps the bytes the host asked to change. It then enables writes and erases the sector, and polls the status register until the erase finishes. Last, it programs the buffer back one page at a time, with its own write enable and status poll for each page.

The host loads patch bytes while the block is idle. Each patch is a byte offset within the sector and a new value. The host then pulses `start` with a sector index. Each patched offset is marked in the buffer, and the copy from flash does not overwrite marked entries. The image that is programmed back is therefore the old sector contents with the patches applied. The marks are dropped when a run ends. The flash link is single-bit SPI in mode 0: the clock idles low, data is sampled on the rising edge, and one SPI clock period is two system clocks.

Top module: `sector_rewrite_seq`

## Requirements
- R1: While reset is held and after it is released, `busy`, `done` and `error` are low, `spi_cs_n` is high and `spi_sck` is low.
- R2: A start accepted while idle first reads the whole sector in one chip-select window. The window holds opcode 0x03, a 24-bit address sent MSB first and equal to sector index × SECTOR_BYTES, and then SECTOR_BYTES data bytes. The erase follows only after this read.
- R3: After a successful run, each patched offset holds its patch value and every other byte of the sector holds its earlier value. Other sectors are unchanged.
- R4: A write-enable window (opcode 0x06, one byte) comes right before the erase and right before every page program.
- R5: The erase window carries opcode 0xD8 and three address bytes, and nothing else. Chip select rises right after the last address bit.
- R6: After the erase and after each page program, the block reads status (opcode 0x05 plus one byte; bit 0 is the write-in-progress flag). It repeats the read until bit 0 is 0 and issues no other command before then.
- R7: Write-back uses opcode 0x02, a page-aligned 24-bit address and exactly PAGE_BYTES data bytes per window, with pages in ascending order.
- R8: Chip select stays high for at least MIN_GAP clocks between windows, and `spi_sck` is low whenever chip select is high.
- R9: If MAX_POLLS status reads in a row all show bit 0 set, the block raises `error` and returns to idle without any further command. `error` stays high until the next accepted start.
- R10: `start` and patch writes are ignored while `busy` is high.
- R11: A successful run ends with a one-cycle `done` pulse in the cycle `busy` falls. Patches from a finished run do not carry into the next one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a rewrite of the selected sector |
| sector_idx | input | SECTOR_IDX_W | Sector to rewrite |
| patch_we | input | 1 | Write one patch byte (used only while idle) |
| patch_off | input | log2(SECTOR_BYTES) | Byte offset of the patch within the sector |
| patch_data | input | 8 | New byte value |
| spi_sck | output | 1 | SPI clock, idle low |
| spi_cs_n | output | 1 | SPI chip select, active low |
| spi_mosi | output | 1 | Serial data to flash |
| spi_miso | input | 1 | Serial data from flash |
| busy | output | 1 | A rewrite is in progress |
| done | output | 1 | One-cycle pulse on successful completion |
| error | output | 1 | Status poll limit reached; held until next start |

## Verification
On every cycle the assertions check the bus framing rules: the minimum chip-select high time, the clock idling low outside a window, and that patch and fill writes never collide in the buffer. They also check that `done` and a new `error` appear only as the block drops `busy`, and that a start during a run leaves the latched sector unchanged. The checks that need a flash model come only from the bench scenarios. These are the command order, write enable before each erase and page program, the exact number of polls while the flash reports busy, the addresses sent, and the final sector image with patches merged. The bench also shows that patches are cleared between runs, and that `error` stays high and then clears on the next start.

// File: rtl/srw_pkg.sv
// Shared opcodes and state types for the sector rewrite sequencer.
// Assumes a flash with a 24-bit address and the usual single-bit command set.
package srw_pkg;
    localparam logic [7:0] OPC_READ  = 8'h03;
    localparam logic [7:0] OPC_WREN  = 8'h06;
    localparam logic [7:0] OPC_ERASE = 8'hD8;
    localparam logic [7:0] OPC_RDSR  = 8'h05;
    localparam logic [7:0] OPC_PROG  = 8'h02;

    // Command currently framed on the bus, in the order a run visits them.
    typedef enum logic [2:0] {
        OP_READ, OP_WREN_E, OP_ERASE, OP_POLL_E, OP_WREN_P, OP_PROG, OP_POLL_P
    } op_e;

    typedef enum logic [1:0] {PH_IDLE, PH_GAP, PH_XFER} phase_e;

    function automatic logic [7:0] opcode_of(op_e op);
        case (op)
            OP_READ:              return OPC_READ;
            OP_WREN_E, OP_WREN_P: return OPC_WREN;
            OP_ERASE:             return OPC_ERASE;
            OP_PROG:              return OPC_PROG;
            default:              return OPC_RDSR;
        endcase
    endfunction
endpackage

// File: rtl/srw_spi_byte.sv
// One-byte SPI mode 0 shifter. A pulse on go sends tx_byte MSB first while
// capturing miso on each rising sck; done pulses once sck has returned low.
// Assumes go arrives only while the shifter is idle. SCK runs at clk/2.
module srw_spi_byte (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       go,
    input  logic [7:0] tx_byte,
    input  logic       miso,
    output logic       sck,
    output logic       mosi,
    output logic [7:0] rx_byte,
    output logic       done
);
    logic       active;
    logic [2:0] bit_cnt;
    logic [7:0] sh;

    // Clock phase toggling, bit shifting and capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active  <= 1'b0;
            sck     <= 1'b0;
            bit_cnt <= '0;
            sh      <= '0;
            rx_byte <= '0;
            done    <= 1'b0;
        end else begin
            done <= 1'b0;
            if (!active) begin
                if (go) begin
                    active  <= 1'b1;
                    sh      <= tx_byte;
                    bit_cnt <= '0;
                end
            end else if (!sck) begin
                sck     <= 1'b1;
                rx_byte <= {rx_byte[6:0], miso};
            end else begin
                sck <= 1'b0;
                if (bit_cnt == 3'd7) begin
                    active <= 1'b0;
                    done   <= 1'b1;
                end else begin
                    bit_cnt <= bit_cnt + 3'd1;
                    sh      <= {sh[6:0], 1'b0};
                end
            end
        end
    end

    assign mosi = sh[7];

    assert_go_when_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        go |-> !sck);
endmodule

// File: rtl/srw_sector_buf.sv
// Sector image buffer with a per-byte patch mark. Patch writes store a byte
// and mark it; fill writes from the flash read skip marked bytes. clear drops
// all marks, and a patch in the same cycle still marks its byte.
module srw_sector_buf #(
    parameter int DEPTH = 512,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          patch_we,
    input  logic [AW-1:0] patch_addr,
    input  logic [7:0]    patch_data,
    input  logic          fill_we,
    input  logic [AW-1:0] fill_addr,
    input  logic [7:0]    fill_data,
    input  logic          clear,
    input  logic [AW-1:0] raddr,
    output logic [7:0]    rdata
);
    logic [7:0]       mem [DEPTH];
    logic [DEPTH-1:0] mark;

    // Data storage: a patch has priority, a fill respects the marks.
    always_ff @(posedge clk) begin
        if (patch_we)
            mem[patch_addr] <= patch_data;
        else if (fill_we && !mark[fill_addr])
            mem[fill_addr] <= fill_data;
    end

    // Patch marks: set by patch writes, dropped at the end of a run.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mark <= '0;
        end else begin
            if (clear)
                mark <= '0;
            if (patch_we)
                mark[patch_addr] <= 1'b1;
        end
    end

    assign rdata = mem[raddr];

    assert_patch_fill_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(patch_we && fill_we));
endmodule

// File: rtl/sector_rewrite_seq.sv
// Sector rewrite sequencer. On start it reads the sector, erases it behind a
// write enable, polls status, then programs the merged image back page by page,
// each behind a write enable and followed by a poll. Assumes 24-bit addressing,
// SECTOR_BYTES a power of two and a multiple of PAGE_BYTES, and MIN_GAP >= 1.
module sector_rewrite_seq
    import srw_pkg::*;
#(
    parameter int SECTOR_BYTES = 512,
    parameter int PAGE_BYTES   = 256,
    parameter int SECTOR_IDX_W = 4,
    parameter int MIN_GAP      = 4,
    parameter int MAX_POLLS    = 64
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            start,
    input  logic [SECTOR_IDX_W-1:0]         sector_idx,
    input  logic                            patch_we,
    input  logic [$clog2(SECTOR_BYTES)-1:0] patch_off,
    input  logic [7:0]                      patch_data,
    output logic                            spi_sck,
    output logic                            spi_cs_n,
    output logic                            spi_mosi,
    input  logic                            spi_miso,
    output logic                            busy,
    output logic                            done,
    output logic                            error
);
    localparam int ADDR_W = 24;
    localparam int BUF_AW = $clog2(SECTOR_BYTES);
    localparam int PAGES  = SECTOR_BYTES / PAGE_BYTES;
    localparam int PG_W   = (PAGES > 1) ? $clog2(PAGES) : 1;
    localparam int IDX_W  = $clog2(SECTOR_BYTES + 4) + 1;
    localparam int GAP_W  = $clog2(MIN_GAP + 1);
    localparam int POLL_W = $clog2(MAX_POLLS + 1);

    phase_e                  phase;
    op_e                     op;
    logic [IDX_W-1:0]        byte_idx;
    logic [PG_W-1:0]         page_q;
    logic [POLL_W-1:0]       poll_q;
    logic [GAP_W-1:0]        gap_q;
    logic [SECTOR_IDX_W-1:0] sec_q;
    logic                    cs_n_q, sh_go, busy_q, done_q, err_q, clr_q;
    logic [7:0]              sh_tx;

    logic                    sh_done;
    logic [7:0]              sh_rx, tx_next, buf_rdata;
    logic [IDX_W-1:0]        last_idx, tx_idx, data_idx;
    logic [ADDR_W-1:0]       sec_base, cmd_addr;
    logic [BUF_AW-1:0]       buf_raddr;
    logic                    fill_we, patch_ok;

    // Last byte index of the window for each command.
    always_comb begin
        case (op)
            OP_READ:              last_idx = IDX_W'(SECTOR_BYTES + 3);
            OP_PROG:              last_idx = IDX_W'(PAGE_BYTES + 3);
            OP_ERASE:             last_idx = IDX_W'(3);
            OP_WREN_E, OP_WREN_P: last_idx = '0;
            default:              last_idx = IDX_W'(1);
        endcase
    end

    // Next byte to shift: opcode, then address MSB first, then payload.
    always_comb begin
        tx_idx    = (phase == PH_XFER) ? byte_idx + IDX_W'(1) : '0;
        data_idx  = tx_idx - IDX_W'(4);
        sec_base  = ADDR_W'(sec_q) * ADDR_W'(SECTOR_BYTES);
        cmd_addr  = (op == OP_PROG) ? sec_base + ADDR_W'(page_q) * ADDR_W'(PAGE_BYTES)
                                    : sec_base;
        buf_raddr = BUF_AW'(page_q) * BUF_AW'(PAGE_BYTES) + BUF_AW'(data_idx);
        if (tx_idx == '0)
            tx_next = opcode_of(op);
        else if (tx_idx < IDX_W'(4))
            case (tx_idx[1:0])
                2'd1:    tx_next = cmd_addr[23:16];
                2'd2:    tx_next = cmd_addr[15:8];
                default: tx_next = cmd_addr[7:0];
            endcase
        else if (op == OP_PROG)
            tx_next = buf_rdata;
        else
            tx_next = 8'h00;
    end

    assign fill_we  = (phase == PH_XFER) && sh_done && (op == OP_READ) && (byte_idx >= IDX_W'(4));
    assign patch_ok = patch_we && (phase == PH_IDLE);

    // Run control: command order, framing, poll limit and page stepping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase    <= PH_IDLE;
            op       <= OP_READ;
            byte_idx <= '0;
            page_q   <= '0;
            poll_q   <= '0;
            gap_q    <= '0;
            sec_q    <= '0;
            cs_n_q   <= 1'b1;
            sh_go    <= 1'b0;
            sh_tx    <= '0;
            busy_q   <= 1'b0;
            done_q   <= 1'b0;
            err_q    <= 1'b0;
            clr_q    <= 1'b0;
        end else begin
            sh_go  <= 1'b0;
            done_q <= 1'b0;
            clr_q  <= 1'b0;
            case (phase)
                PH_IDLE: if (start) begin
                    busy_q <= 1'b1;
                    err_q  <= 1'b0;
                    sec_q  <= sector_idx;
                    op     <= OP_READ;
                    page_q <= '0;
                    gap_q  <= '0;
                    phase  <= PH_GAP;
                end
                PH_GAP: if (gap_q == GAP_W'(MIN_GAP - 1)) begin
                    cs_n_q   <= 1'b0;
                    byte_idx <= '0;
                    sh_go    <= 1'b1;
                    sh_tx    <= tx_next;
                    phase    <= PH_XFER;
                end else begin
                    gap_q <= gap_q + GAP_W'(1);
                end
                default: if (sh_done) begin
                    if (byte_idx != last_idx) begin
                        byte_idx <= byte_idx + IDX_W'(1);
                        sh_go    <= 1'b1;
                        sh_tx    <= tx_next;
                    end else begin
                        cs_n_q <= 1'b1;
                        gap_q  <= '0;
                        phase  <= PH_GAP;
                        case (op)
                            OP_READ:   op <= OP_WREN_E;
                            OP_WREN_E: op <= OP_ERASE;
                            OP_WREN_P: op <= OP_PROG;
                            OP_ERASE, OP_PROG: begin
                                op     <= (op == OP_ERASE) ? OP_POLL_E : OP_POLL_P;
                                poll_q <= '0;
                            end
                            default: begin
                                if (!sh_rx[0]) begin
                                    if (op == OP_POLL_E) begin
                                        op     <= OP_WREN_P;
                                        page_q <= '0;
                                    end else if (page_q == PG_W'(PAGES - 1)) begin
                                        phase  <= PH_IDLE;
                                        busy_q <= 1'b0;
                                        done_q <= 1'b1;
                                        clr_q  <= 1'b1;
                                    end else begin
                                        page_q <= page_q + PG_W'(1);
                                        op     <= OP_WREN_P;
                                    end
                                end else if (poll_q == POLL_W'(MAX_POLLS - 1)) begin
                                    phase  <= PH_IDLE;
                                    busy_q <= 1'b0;
                                    err_q  <= 1'b1;
                                    clr_q  <= 1'b1;
                                end else begin
                                    poll_q <= poll_q + POLL_W'(1);
                                end
                            end
                        endcase
                    end
                end
            endcase
        end
    end

    srw_spi_byte u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .go      (sh_go),
        .tx_byte (sh_tx),
        .miso    (spi_miso),
        .sck     (spi_sck),
        .mosi    (spi_mosi),
        .rx_byte (sh_rx),
        .done    (sh_done)
    );

    srw_sector_buf #(.DEPTH(SECTOR_BYTES), .AW(BUF_AW)) u_buf (
        .clk        (clk),
        .rst_n      (rst_n),
        .patch_we   (patch_ok),
        .patch_addr (patch_off),
        .patch_data (patch_data),
        .fill_we    (fill_we),
        .fill_addr  (BUF_AW'(byte_idx - IDX_W'(4))),
        .fill_data  (sh_rx),
        .clear      (clr_q),
        .raddr      (buf_raddr),
        .rdata      (buf_rdata)
    );

    assign spi_cs_n = cs_n_q;
    assign busy     = busy_q;
    assign done     = done_q;
    assign error    = err_q;

    // Checker state: clocks seen with chip select high.
    logic [GAP_W-1:0] hi_cnt;
    always_ff @(posedge clk) begin
        if (!rst_n)
            hi_cnt <= '0;
        else if (!spi_cs_n)
            hi_cnt <= '0;
        else if (hi_cnt != GAP_W'(MIN_GAP))
            hi_cnt <= hi_cnt + GAP_W'(1);
    end

    assert_cs_gap_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(spi_cs_n) |-> hi_cnt >= GAP_W'(MIN_GAP));
    assert_sck_low_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        spi_cs_n |-> !spi_sck);
    assert_start_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> $stable(sec_q));
    assert_done_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && !error && spi_cs_n));
    assert_error_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(error) |-> (!busy && spi_cs_n));
endmodule

// File: tb/sector_rewrite_seq_bench.sv
module sector_rewrite_seq_bench;
    localparam int SEC = 512;
    localparam int PG = 256;
    localparam int MIN_GAP = 4;
    localparam int MAX_POLLS = 64;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [3:0] sector_idx = '0;
    logic patch_we = 1'b0;
    logic [8:0] patch_off = '0;
    logic [7:0] patch_data = '0;
    logic spi_miso = 1'b0;
    logic spi_sck, spi_cs_n, spi_mosi, busy, done, error;

    always #5 clk = ~clk;

    sector_rewrite_seq u_sector_rewrite_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .sector_idx(sector_idx),
        .patch_we(patch_we), .patch_off(patch_off), .patch_data(patch_data),
        .spi_sck(spi_sck), .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi), .spi_miso(spi_miso),
        .busy(busy), .done(done), .error(error)
    );

    int tests = 0, fails = 0;
    bit finished = 1'b0;

    // ---------------- flash model ----------------
    logic [7:0] fmem [0:4095];
    logic [7:0] exp_mem [0:4095];
    logic [7:0] pp_buf [0:255];
    logic [7:0] in_sh = '0, cur_op = '0, out_sh = '0;
    logic [23:0] maddr = '0, read_addr = '0, erase_addr = '0;
    logic [23:0] pp_addr [0:7];
    int bitn = 0, bytec = 0, rd_k = 0, pp_n = 0;
    bit wel = 1'b0;
    int wip_left = 0, busy_polls = 0, stage = 0;
    int n_read = 0, n_erase = 0, n_pp = 0, n_rdsr = 0;
    int viol_wel = 0, viol_busy = 0, viol_order = 0, viol_frame = 0, viol_gap = 0;
    int done_cnt = 0, gap_run = 0;
    bit prev_cs = 1'b1;

    always @(negedge spi_cs_n) begin
        bitn = 0; bytec = 0; pp_n = 0; in_sh = '0; cur_op = '0; out_sh = '0;
    end

    always @(posedge spi_sck) begin
        if (!spi_cs_n) begin
            in_sh = {in_sh[6:0], spi_mosi};
            bitn++;
            if (bitn == 8) begin
                bitn = 0;
                bytec++;
                if (bytec == 1) begin
                    cur_op = in_sh;
                    if (wip_left > 0 && in_sh != 8'h05) viol_busy++;
                    if (in_sh == 8'h05) begin
                        n_rdsr++;
                        out_sh = {6'b0, wel, (wip_left > 0)};
                    end
                end else if (cur_op == 8'h05) begin
                    if (bytec == 2 && wip_left > 0) wip_left--;
                end else if (bytec <= 4) begin
                    maddr = {maddr[15:0], in_sh};
                    if (bytec == 4 && cur_op == 8'h03) begin
                        out_sh = fmem[int'(maddr[11:0])];
                        rd_k = 1;
                    end
                end else if (cur_op == 8'h03) begin
                    out_sh = fmem[(int'(maddr[11:0]) + rd_k) % 4096];
                    rd_k++;
                end else if (cur_op == 8'h02) begin
                    if (pp_n < 256) pp_buf[pp_n] = in_sh;
                    pp_n++;
                end
            end
        end
    end

    always @(negedge spi_sck) begin
        if (!spi_cs_n) begin
            spi_miso = out_sh[7];
            out_sh = {out_sh[6:0], 1'b0};
        end
    end

    // Command execution when a window closes.
    always @(posedge spi_cs_n) begin
        if (bytec != 0) begin
            if (bitn != 0) viol_frame++;
            case (cur_op)
                8'h06: if (bytec == 1) wel = 1'b1; else viol_frame++;
                8'h03: begin
                    if (bytec == 4 + SEC) begin if (stage == 0) stage = 1; end
                    else viol_frame++;
                    n_read++;
                    read_addr = maddr;
                end
                8'hD8: if (bytec == 4) begin
                    if (!wel) viol_wel++;
                    else begin
                        if (stage != 1) viol_order++;
                        stage = 2;
                        erase_addr = maddr;
                        n_erase++;
                        for (int i = 0; i < SEC; i++)
                            fmem[(int'(maddr[11:0]) & ~(SEC - 1)) + i] = 8'hFF;
                        wel = 1'b0;
                        wip_left = busy_polls;
                    end
                end else viol_frame++;
                8'h02: if (bytec == 4 + PG && maddr[7:0] == 8'h00) begin
                    if (!wel) viol_wel++;
                    else begin
                        if (stage != 2) viol_order++;
                        if (n_pp < 8) pp_addr[n_pp] = maddr;
                        n_pp++;
                        for (int i = 0; i < PG; i++)
                            fmem[int'(maddr[11:0]) + i] = fmem[int'(maddr[11:0]) + i] & pp_buf[i];
                        wel = 1'b0;
                        wip_left = busy_polls;
                    end
                end else viol_frame++;
                8'h05: if (bytec != 2) viol_frame++;
                default: viol_frame++;
            endcase
        end
    end

    // Bus timing monitor and done pulse counter, sampled away from the edge.
    always @(negedge clk) begin
        if (rst_n) begin
            if (spi_cs_n) begin
                gap_run++;
                if (spi_sck) viol_gap++;
            end else begin
                if (prev_cs && gap_run < MIN_GAP) viol_gap++;
                gap_run = 0;
            end
            prev_cs = spi_cs_n;
            if (done) done_cnt++;
        end
    end

    // ---------------- helpers ----------------
    function automatic logic [7:0] pat(input int seed, input int a);
        return 8'((a * 13 + seed * 29 + (a >> 8)) ^ 8'h5C);
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic fill_flash(input int seed);
        for (int i = 0; i < 4096; i++) begin
            fmem[i] = pat(seed, i);
            exp_mem[i] = fmem[i];
        end
    endtask

    task automatic clear_model(input int polls);
        busy_polls = polls; wip_left = 0; stage = 0; wel = 1'b0;
        n_read = 0; n_erase = 0; n_pp = 0; n_rdsr = 0;
        viol_wel = 0; viol_busy = 0; viol_order = 0; viol_frame = 0; viol_gap = 0;
        done_cnt = 0;
    endtask

    task automatic put_patch(input int sec, input int off, input logic [7:0] val);
        @(negedge clk);
        patch_we = 1'b1; patch_off = 9'(off); patch_data = val;
        @(negedge clk);
        patch_we = 1'b0;
        exp_mem[sec * SEC + off] = val;
    endtask

    task automatic pulse_start(input int sec);
        @(negedge clk);
        start = 1'b1; sector_idx = 4'(sec);
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_idle();
        @(negedge clk);
        while (busy) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    function automatic int mem_mismatch();
        int n = 0;
        for (int i = 0; i < 4096; i++) if (fmem[i] !== exp_mem[i]) n++;
        return n;
    endfunction

    // ---------------- scenarios ----------------
    task automatic t_reset();
        check(busy === 1'b0 && done === 1'b0 && error === 1'b0, "R1", "flags after reset",
              {busy, done, error}, 0);
        check(spi_cs_n === 1'b1 && spi_sck === 1'b0, "R1", "bus idle after reset",
              {spi_cs_n, spi_sck}, 2);
    endtask

    task automatic t_basic();
        fill_flash(1);
        clear_model(3);
        put_patch(1, 0, ~pat(1, 512));
        put_patch(1, 100, ~pat(1, 612));
        put_patch(1, 255, ~pat(1, 767));
        put_patch(1, 256, ~pat(1, 768));
        put_patch(1, 511, ~pat(1, 1023));
        pulse_start(1);
        wait_idle();
        check(mem_mismatch() == 0, "R3", "image after patched rewrite", mem_mismatch(), 0);
        check(n_read == 1 && read_addr == 24'd512, "R2", "sector read address", read_addr, 512);
        check(viol_order == 0, "R2", "read-erase-program order", viol_order, 0);
        check(viol_wel == 0, "R4", "write enable before erase/program", viol_wel, 0);
        check(n_erase == 1 && erase_addr == 24'd512 && viol_frame == 0, "R5", "erase framing",
              erase_addr, 512);
        check(viol_busy == 0 && n_rdsr == 12, "R6", "status polls", n_rdsr, 12);
        check(n_pp == 2 && pp_addr[0] == 24'd512 && pp_addr[1] == 24'd768, "R7",
              "page program addresses", pp_addr[1], 768);
        check(viol_gap == 0, "R8", "cs high time and idle sck", viol_gap, 0);
        check(done_cnt == 1 && error == 1'b0, "R11", "single done pulse", done_cnt, 1);
    endtask

    task automatic t_ignored();
        fill_flash(2);
        clear_model(1);
        pulse_start(2);
        repeat (200) @(negedge clk);
        start = 1'b1; sector_idx = 4'd6;
        patch_we = 1'b1; patch_off = 9'd10; patch_data = ~pat(2, 1034);
        @(negedge clk);
        start = 1'b0; patch_we = 1'b0;
        wait_idle();
        check(mem_mismatch() == 0, "R10", "patch while busy left no trace", mem_mismatch(), 0);
        check(n_erase == 1 && erase_addr == 24'd1024, "R10", "second start ignored",
              erase_addr, 1024);
        check(done_cnt == 1, "R10", "one completion", done_cnt, 1);
    endtask

    task automatic t_mask_clear();
        fill_flash(3);
        clear_model(2);
        pulse_start(1);
        wait_idle();
        check(mem_mismatch() == 0, "R11", "earlier patches not reapplied", mem_mismatch(), 0);
        check(viol_busy == 0 && n_rdsr == 9, "R6", "polls with two busy reads", n_rdsr, 9);
    endtask

    task automatic t_last_sector();
        fill_flash(4);
        clear_model(0);
        put_patch(7, 300, ~pat(4, 3884));
        pulse_start(7);
        wait_idle();
        check(mem_mismatch() == 0, "R3", "last sector image", mem_mismatch(), 0);
        check(read_addr == 24'd3584 && erase_addr == 24'd3584, "R2", "last sector base",
              read_addr, 3584);
        check(pp_addr[0] == 24'd3584 && pp_addr[1] == 24'd3840, "R7", "last sector pages",
              pp_addr[0], 3584);
        check(n_rdsr == 3, "R6", "single poll when ready", n_rdsr, 3);
    endtask

    task automatic t_timeout();
        fill_flash(5);
        clear_model(1000);
        pulse_start(3);
        wait_idle();
        check(error === 1'b1 && busy === 1'b0, "R9", "error after poll limit", {error, busy}, 2);
        check(n_rdsr == MAX_POLLS, "R9", "poll count at limit", n_rdsr, MAX_POLLS);
        check(n_pp == 0 && done_cnt == 0, "R9", "no program after timeout", n_pp, 0);
        repeat (20) @(negedge clk);
        check(error === 1'b1, "R9", "error held", error, 1);
        for (int i = 0; i < SEC; i++) exp_mem[3 * SEC + i] = 8'hFF;
        clear_model(0);
        pulse_start(3);
        @(negedge clk);
        check(error === 1'b0, "R9", "error cleared by start", error, 0);
        wait_idle();
        check(done_cnt == 1 && mem_mismatch() == 0, "R9", "run after error", mem_mismatch(), 0);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        t_reset();
        t_basic();
        t_ignored();
        t_mask_clear();
        t_last_sector();
        t_timeout();
        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            tests++;
            fails++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule